// File: doc/BRIEF.md
# Pipeline hazard and forwarding control

This block is the control logic for a five-stage in-order RV32 pipeline (fetch, decode, execute, memory, writeback). For each of the two execute-stage source operands it picks where the value comes from. The choices are the result held in the execute/memory latch, the result held in the memory/writeback latch, or the plain register file read.

It combines three stall requests into one freeze. The requests are bus back-pressure, divider busy and atomic unit busy. During a freeze every pipeline register is told to hold its value. When the execute stage resolves a taken branch or jump, the block loads the new PC and turns the two younger instructions into bubbles. Those are the word entering the fetch/decode latch and the instruction leaving decode.

Instruction fetch reads a synchronous memory one cycle behind the PC. For that reason the first unstalled cycle after reset also loads a bubble into the fetch/decode latch. All outputs except the fetch-ready flag are combinational functions of the current inputs. The enclosing datapath applies them at the next clock edge.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: When the execute/memory writer has its write enable set, a non-zero destination, and a destination equal to an operand's source index, that operand's select is 1 (execute/memory latch). Selects are 2 bits: 0 = register file, 1 = execute/memory latch, 2 = memory/writeback latch.
- R2: When only the memory/writeback writer matches an operand (write enable set, non-zero destination equal to the source index), that operand's select is 2.
- R3: When both writers match the same operand, the select is 1; the nearer, younger result wins.
- R4: A destination of register 0, or a cleared write enable, never forwards. With no qualifying match the select is 0.
- R5: The freeze output is the OR of the bus, divider and atomic stall inputs. While it is high all five stage enables are 0; while it is low all are 1. Stage enable bit order: 0 = PC, 1 = fetch/decode latch, 2 = decode/execute latch, 3 = execute/memory latch, 4 = memory/writeback latch.
- R6: A redirect with no freeze raises the PC-load output, the fetch/decode bubble and the decode/execute bubble in the same cycle.
- R7: While frozen, a pending redirect produces no bubble and no PC load. It takes effect on the first cycle without freeze.
- R8: The first cycle without freeze after reset raises the fetch/decode bubble even with no redirect. Frozen cycles before it do not use up this bubble.
- R9: Once that first bubble has been taken, a cycle with no stall and no redirect has all stage enables high and no bubble or PC load, so one instruction advances per clock.
- R10: Operand selects follow the register indices whether or not the pipeline is frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ex_rs1_i | input | REG_AW | Source index of operand A in execute |
| ex_rs2_i | input | REG_AW | Source index of operand B in execute |
| exm_rd_i | input | REG_AW | Destination held in execute/memory latch |
| exm_we_i | input | 1 | Execute/memory latch writes a register |
| mwb_rd_i | input | REG_AW | Destination held in memory/writeback latch |
| mwb_we_i | input | 1 | Memory/writeback latch writes a register |
| stall_bus_i | input | 1 | Bus back-pressure request |
| stall_div_i | input | 1 | Divider busy request |
| stall_amo_i | input | 1 | Atomic unit busy request |
| redirect_i | input | 1 | Execute resolved a taken branch or jump |
| fwd_a_o | output | 2 | Operand A source select |
| fwd_b_o | output | 2 | Operand B source select |
| freeze_o | output | 1 | Merged stall |
| stage_en_o | output | 5 | Per-stage register enables |
| pc_load_o | output | 1 | Load the redirect target into the PC |
| ifid_bubble_o | output | 1 | Insert bubble into fetch/decode latch |
| idex_bubble_o | output | 1 | Insert bubble into decode/execute latch |

## Verification
The bench builds the block with its default 5-bit register index. The full 32-entry register space is therefore reachable, including register 0 and collisions where both writers share a destination. Drawing indices from a narrowed random range of 0 to 7 makes matches on both writers, and matches on register 0, frequent. This exercises the priority rule and the register-0 exclusion many times. Random stall and redirect combinations also cover redirects arriving during each of the three stall sources.

// File: rtl/hz_pkg.sv
package hz_pkg;

    localparam int REG_AW    = 5;
    localparam int NUM_STALL = 3;
    localparam int NUM_STAGE = 5;

    // stage enable bit positions
    localparam int ST_PC   = 0;
    localparam int ST_IFID = 1;
    localparam int ST_IDEX = 2;
    localparam int ST_EXM  = 3;
    localparam int ST_MWB  = 4;

    // stall request bit positions
    localparam int SR_BUS = 0;
    localparam int SR_DIV = 1;
    localparam int SR_AMO = 2;

    typedef enum logic [1:0] {
        FWD_RF  = 2'd0,
        FWD_EXM = 2'd1,
        FWD_MWB = 2'd2
    } fwd_sel_e;

    typedef struct packed {
        logic              we;
        logic [REG_AW-1:0] rd;
    } wr_port_t;

    function automatic logic wr_hits(wr_port_t w, logic [REG_AW-1:0] idx);
        return w.we && (w.rd != '0) && (w.rd == idx);
    endfunction

endpackage

// File: rtl/hz_fwd_unit.sv
module hz_fwd_unit
    import hz_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_AW-1:0] src_idx,
    input  wr_port_t          near_wr,
    input  wr_port_t          far_wr,
    output fwd_sel_e          sel
);

    logic near_hit;
    logic far_hit;

    assign near_hit = wr_hits(near_wr, src_idx);
    assign far_hit  = wr_hits(far_wr, src_idx);

    always_comb begin
        if (near_hit)
            sel = FWD_EXM;
        else if (far_hit)
            sel = FWD_MWB;
        else
            sel = FWD_RF;
    end

    // R4: register 0 is never a forwarding source
    a_r4_x0_from_rf: assert property (@(posedge clk) disable iff (rst)
        (src_idx == '0) |-> (sel == FWD_RF));

    // R3: when both latches carry the index, the younger one is selected
    a_r3_near_priority: assert property (@(posedge clk) disable iff (rst)
        (near_wr.we && far_wr.we && near_wr.rd == far_wr.rd &&
         near_wr.rd == src_idx && src_idx != '0) |-> (sel == FWD_EXM));

    // R2: memory/writeback is only chosen when that latch writes the index
    a_r2_far_needs_match: assert property (@(posedge clk) disable iff (rst)
        (sel == FWD_MWB) |-> (far_wr.we && far_wr.rd == src_idx));

endmodule

// File: rtl/hz_stall_merge.sv
module hz_stall_merge
    import hz_pkg::*;
#(
    parameter int N_REQ   = NUM_STALL,
    parameter int N_STAGE = NUM_STAGE
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_REQ-1:0]   req,
    output logic               freeze,
    output logic [N_STAGE-1:0] stage_en
);

    assign freeze = |req;

    for (genvar s = 0; s < N_STAGE; s++) begin : g_en
        assign stage_en[s] = ~freeze;
    end

    // R5: any request holds every stage register
    a_r5_hold_all: assert property (@(posedge clk) disable iff (rst)
        (req != '0) |-> (stage_en == '0));

    // R5: with no request every stage advances
    a_r5_run_all: assert property (@(posedge clk) disable iff (rst)
        (req == '0) |-> (&stage_en));

endmodule

// File: rtl/hz_flush_ctrl.sv
module hz_flush_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic freeze,
    input  logic redirect,
    output logic pc_load,
    output logic ifid_bubble,
    output logic idex_bubble
);

    // fetch memory output is valid only after one unstalled cycle
    logic fetch_ready;

    always_ff @(posedge clk) begin
        if (rst)
            fetch_ready <= 1'b0;
        else if (!freeze)
            fetch_ready <= 1'b1;
    end

    logic take_redirect;
    assign take_redirect = redirect && !freeze;

    assign pc_load     = take_redirect;
    assign idex_bubble = take_redirect;
    assign ifid_bubble = !freeze && (take_redirect || !fetch_ready);

    // R7: nothing is squashed while frozen
    a_r7_no_squash_frozen: assert property (@(posedge clk) disable iff (rst)
        freeze |-> (!ifid_bubble && !idex_bubble && !pc_load));

    // R6: an accepted redirect squashes both younger stages together
    a_r6_two_bubbles: assert property (@(posedge clk) disable iff (rst)
        pc_load |-> (ifid_bubble && idex_bubble));

    // R8: once an unstalled cycle has passed, the fetch is primed for good
    a_r8_ready_sticky: assert property (@(posedge clk) disable iff (rst)
        (ifid_bubble && !redirect) |=> !(ifid_bubble && !redirect && !freeze));

endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
    import hz_pkg::*;
#(
    parameter int AW = REG_AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ex_rs1_i,
    input  logic [AW-1:0] ex_rs2_i,
    input  logic [AW-1:0] exm_rd_i,
    input  logic          exm_we_i,
    input  logic [AW-1:0] mwb_rd_i,
    input  logic          mwb_we_i,
    input  logic          stall_bus_i,
    input  logic          stall_div_i,
    input  logic          stall_amo_i,
    input  logic          redirect_i,
    output logic [1:0]    fwd_a_o,
    output logic [1:0]    fwd_b_o,
    output logic          freeze_o,
    output logic [4:0]    stage_en_o,
    output logic          pc_load_o,
    output logic          ifid_bubble_o,
    output logic          idex_bubble_o
);

    localparam int N_SRC = 2;

    wr_port_t              near_wr;
    wr_port_t              far_wr;
    logic [REG_AW-1:0]     src_idx [N_SRC];
    fwd_sel_e              src_sel [N_SRC];
    logic [NUM_STALL-1:0]  stall_req;
    logic                  freeze;

    assign near_wr = '{we: exm_we_i, rd: REG_AW'(exm_rd_i)};
    assign far_wr  = '{we: mwb_we_i, rd: REG_AW'(mwb_rd_i)};

    assign src_idx[0] = REG_AW'(ex_rs1_i);
    assign src_idx[1] = REG_AW'(ex_rs2_i);

    for (genvar i = 0; i < N_SRC; i++) begin : g_fwd
        hz_fwd_unit u_fwd (
            .clk     (clk),
            .rst     (rst),
            .src_idx (src_idx[i]),
            .near_wr (near_wr),
            .far_wr  (far_wr),
            .sel     (src_sel[i])
        );
    end

    assign fwd_a_o = src_sel[0];
    assign fwd_b_o = src_sel[1];

    always_comb begin
        stall_req         = '0;
        stall_req[SR_BUS] = stall_bus_i;
        stall_req[SR_DIV] = stall_div_i;
        stall_req[SR_AMO] = stall_amo_i;
    end

    hz_stall_merge #(
        .N_REQ   (NUM_STALL),
        .N_STAGE (NUM_STAGE)
    ) u_stall (
        .clk      (clk),
        .rst      (rst),
        .req      (stall_req),
        .freeze   (freeze),
        .stage_en (stage_en_o)
    );

    assign freeze_o = freeze;

    hz_flush_ctrl u_flush (
        .clk         (clk),
        .rst         (rst),
        .freeze      (freeze),
        .redirect    (redirect_i),
        .pc_load     (pc_load_o),
        .ifid_bubble (ifid_bubble_o),
        .idex_bubble (idex_bubble_o)
    );

    // R10: selects keep tracking indices during a freeze
    a_r10_fwd_in_freeze: assert property (@(posedge clk) disable iff (rst)
        (freeze && exm_we_i && exm_rd_i != '0 && exm_rd_i == ex_rs1_i)
            |-> (fwd_a_o == 2'd1));

endmodule

// File: tb/pipe_hazard_ctrl_test.sv
module pipe_hazard_ctrl_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] ex_rs1 = '0, ex_rs2 = '0, exm_rd = '0, mwb_rd = '0;
    logic       exm_we = 1'b0, mwb_we = 1'b0;
    logic       s_bus = 1'b0, s_div = 1'b0, s_amo = 1'b0, redir = 1'b0;
    logic [1:0] fwd_a, fwd_b;
    logic       freeze, pc_load, ifid_b, idex_b;
    logic [4:0] stage_en;

    int n_chk = 0;
    int n_bad = 0;
    bit primed_m = 1'b0;

    always #2.5 clk = ~clk;

    pipe_hazard_ctrl uut (
        .clk(clk), .rst(rst),
        .ex_rs1_i(ex_rs1), .ex_rs2_i(ex_rs2),
        .exm_rd_i(exm_rd), .exm_we_i(exm_we),
        .mwb_rd_i(mwb_rd), .mwb_we_i(mwb_we),
        .stall_bus_i(s_bus), .stall_div_i(s_div), .stall_amo_i(s_amo),
        .redirect_i(redir),
        .fwd_a_o(fwd_a), .fwd_b_o(fwd_b), .freeze_o(freeze),
        .stage_en_o(stage_en), .pc_load_o(pc_load),
        .ifid_bubble_o(ifid_b), .idex_bubble_o(idex_b)
    );

    function automatic logic [1:0] exp_sel(logic [4:0] rs);
        logic nh, fh;
        nh = exm_we && exm_rd != 0 && exm_rd == rs;
        fh = mwb_we && mwb_rd != 0 && mwb_rd == rs;
        return nh ? 2'd1 : (fh ? 2'd2 : 2'd0);
    endfunction

    function automatic string sel_tag(logic [4:0] rs);
        logic nh, fh;
        nh = exm_we && exm_rd != 0 && exm_rd == rs;
        fh = mwb_we && mwb_rd != 0 && mwb_rd == rs;
        if (nh && fh) return "R3";
        if (nh) return "R1";
        if (fh) return "R2";
        return "R4";
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    // compares every output with the model, then clocks once
    task automatic apply_and_check(string ctx);
        logic fz;
        #1;
        fz = s_bus | s_div | s_amo;
        chk({sel_tag(ex_rs1), " fwd_a ", ctx}, 32'(fwd_a), 32'(exp_sel(ex_rs1)));
        chk({sel_tag(ex_rs2), " fwd_b ", ctx}, 32'(fwd_b), 32'(exp_sel(ex_rs2)));
        chk({"R5 freeze ", ctx}, 32'(freeze), 32'(fz));
        chk({"R5 stage_en ", ctx}, 32'(stage_en), fz ? 32'h0 : 32'h1F);
        chk({fz ? "R7 pc_load " : "R6 pc_load ", ctx}, 32'(pc_load), 32'(redir && !fz));
        chk({fz ? "R7 idex_bubble " : "R6 idex_bubble ", ctx}, 32'(idex_b), 32'(redir && !fz));
        chk({primed_m ? "R9 ifid_bubble " : "R8 ifid_bubble ", ctx}, 32'(ifid_b),
            32'(!fz && (redir || !primed_m)));
        @(posedge clk);
        if (!fz) primed_m = 1'b1;
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        {s_bus, s_div, s_amo, redir, exm_we, mwb_we} = '0;
        ex_rs1 = 0; ex_rs2 = 0; exm_rd = 0; mwb_rd = 0;
    endtask

    initial begin : watchdog
        #(200000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R8: held off by a bus stall, bubble not yet consumed
        s_bus = 1'b1;
        apply_and_check("R8 frozen after reset");
        s_bus = 1'b0;
        // R8: first unstalled cycle inserts fetch bubble
        apply_and_check("R8 first run");
        // R9: steady state
        apply_and_check("R9 steady");

        // R1: back-to-back dependency
        exm_we = 1; exm_rd = 5; ex_rs1 = 5; ex_rs2 = 6;
        apply_and_check("R1 back-to-back");
        // R2: dependency two apart
        idle_inputs();
        mwb_we = 1; mwb_rd = 7; ex_rs2 = 7; ex_rs1 = 3;
        apply_and_check("R2 two apart");
        // R3: both latches write the same register
        exm_we = 1; exm_rd = 7; ex_rs1 = 7;
        apply_and_check("R3 both match");
        // R4: x0 destination ignored
        idle_inputs();
        exm_we = 1; mwb_we = 1; ex_rs1 = 0; ex_rs2 = 0;
        apply_and_check("R4 x0");
        // R4: write enable low ignored
        exm_we = 0; exm_rd = 9; ex_rs1 = 9;
        apply_and_check("R4 we low");
        // R10: selects during freeze
        idle_inputs();
        s_amo = 1; exm_we = 1; exm_rd = 12; ex_rs1 = 12; mwb_we = 1; mwb_rd = 13; ex_rs2 = 13;
        apply_and_check("R10 frozen fwd");

        // R7: redirect held during divider stall
        idle_inputs();
        redir = 1; s_div = 1;
        apply_and_check("R7 div stall");
        s_div = 0; s_amo = 1;
        apply_and_check("R7 amo stall");
        s_amo = 0;
        // R6: redirect takes effect on first unstalled cycle
        apply_and_check("R6 redirect");
        redir = 0;
        // R9: the two younger slots are gone, flow resumes
        apply_and_check("R9 after squash");
        apply_and_check("R9 after squash 2");

        // random mix
        for (int i = 0; i < 600; i++) begin
            ex_rs1 = 5'($urandom_range(0, 7));
            ex_rs2 = 5'($urandom_range(0, 7));
            exm_rd = 5'($urandom_range(0, 7));
            mwb_rd = 5'($urandom_range(0, 7));
            exm_we = 1'($urandom_range(0, 1));
            mwb_we = 1'($urandom_range(0, 1));
            s_bus  = ($urandom_range(0, 5) == 0);
            s_div  = ($urandom_range(0, 5) == 0);
            s_amo  = ($urandom_range(0, 5) == 0);
            redir  = ($urandom_range(0, 3) == 0);
            if (i % 50 == 0) ex_rs1 = 5'($urandom_range(0, 31));
            apply_and_check("random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule